// File: doc/BRIEF.md
# UDP Datagram Detector and Checksum Verifier

This block sits on a 32-bit IP-level word stream and watches each packet as it flows past. It reads the IP protocol number from the header and, when that number is 17, marks the first word of the UDP header with a one-beat start-of-datagram strobe. The source and destination addresses are also taken from the header, so the UDP checksum can be checked over the pseudo-header, the UDP header and the payload as the words go by. No frame is stored. One beat after the last payload word, the block gives a pass/fail result.

The stream passes through one register stage with valid/ready handshaking, and no beat is altered. A beat moves when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output beat and all of its sideband bits hold steady. A packet that is not UDP comes out with no strobe and no checksum result.

Top module: `udp_dgram_check`

## Requirements
- R1: Every accepted input beat appears on the output once, in order, with its data and its `sof`, `sop` and `eof` flags unchanged. The beat leaves the block after one register stage.
- R2: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, all output fields stay stable.
- R3: A packet counts as UDP only when bits [23:16] of its third beat (index 2, counting the `sof` beat as 0) equal 17.
- R4: `out_sod` is high on the output beat that carries `sop` (the first UDP header word) of a UDP packet, and on no other beat. It is never high for a packet that is not UDP.
- R5: The checksum is the 16-bit ones' complement sum of four kinds of field. The first is the source address (beat index 3) and the destination address (beat index 4). The second is the value 17 and the UDP length, which is bits [31:16] of the second UDP header word. The third is both UDP header words, where the checksum field is bits [15:0] of the second word. The fourth is the payload as big-endian 16-bit words. The datagram passes when this sum folds to 0xFFFF.
- R6: A received checksum field of zero reports a pass, whatever the data.
- R7: Payload bytes past the UDP length, such as padding words before `eof` or unused bytes in the last word, are not summed. An odd final byte is summed as the high byte of a word whose low byte is zero.
- R8: `out_ck_vld` is high only on the output beat right after the `eof` beat of a UDP packet, which is the first trailer word. `out_ck_ok` is low on every other beat.
- R9: After reset, `out_valid`, `out_sod` and `out_ck_vld` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take a beat |
| in_data | input | 32 | Input word |
| in_sof | input | 1 | First IP header word |
| in_sop | input | 1 | First word after the IP header |
| in_eof | input | 1 | Last payload word |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Sink takes the beat |
| out_data | output | 32 | Output word |
| out_sof | output | 1 | Passed start-of-frame flag |
| out_sop | output | 1 | Passed start-of-payload flag |
| out_eof | output | 1 | Passed end-of-frame flag |
| out_sod | output | 1 | Start-of-datagram strobe |
| out_ck_vld | output | 1 | Checksum result valid |
| out_ck_ok | output | 1 | Checksum passed |

## Verification
The checks assume well-formed input framing. `sof` opens each packet. `sop` follows at least five beats later. `eof` comes no earlier than the second UDP header word and is followed by two trailer beats before the next `sof`. They also assume the source keeps a beat unchanged until it is accepted. The stimulus builds every packet to this shape: a header of five or six words, random payload lengths, padding and trailer words. It holds each offered beat until it is accepted and inserts random idle cycles and random output stalls.

// File: rtl/udpck_pkg.sv
package udpck_pkg;
  localparam int WORD_W = 32;
  localparam int ACC_W  = 32;

  typedef enum logic [1:0] {PH_IDLE, PH_HDR2, PH_PAY, PH_TAIL} phase_t;

  // end-around carry fold of a wide ones' complement accumulator
  function automatic logic [15:0] fold16(input logic [ACC_W-1:0] a);
    logic [16:0] s;
    s = {1'b0, a[31:16]} + {1'b0, a[15:0]};
    s = {1'b0, s[15:0]} + {16'b0, s[16]};
    return s[15:0];
  endfunction
endpackage

// File: rtl/udpck_hdr_track.sv
module udpck_hdr_track
  import udpck_pkg::*;
#(
  parameter int          IDX_W     = 3,
  parameter int          PROTO_IDX = 2,
  parameter int          SRC_IDX   = 3,
  parameter int          DST_IDX   = 4,
  parameter logic [7:0]  PROTO_UDP = 8'd17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [WORD_W-1:0] data,
  input  logic              sof,
  input  logic              sop,
  input  logic              eof,
  output logic              sod,
  output logic              hdr2,
  output logic              pay,
  output logic              tail,
  output logic [WORD_W-1:0] src_addr,
  output logic [WORD_W-1:0] dst_addr
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [IDX_W-1:0] idx_q, cur_idx;
  logic [7:0]       proto_q;
  phase_t           ph_q, ph_d;

  assign cur_idx = sof ? '0 : idx_q;
  assign sod     = sop && (proto_q == PROTO_UDP);
  assign hdr2    = (ph_q == PH_HDR2);
  assign pay     = (ph_q == PH_PAY);
  assign tail    = (ph_q == PH_TAIL);

  always_comb begin
    ph_d = ph_q;
    if (sof) begin
      ph_d = PH_IDLE;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (sod) ph_d = eof ? PH_TAIL : PH_HDR2;
        PH_HDR2: ph_d = eof ? PH_TAIL : PH_PAY;
        PH_PAY:  if (eof) ph_d = PH_TAIL;
        PH_TAIL: ph_d = PH_IDLE;
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q    <= '0;
      proto_q  <= '0;
      ph_q     <= PH_IDLE;
      src_addr <= '0;
      dst_addr <= '0;
    end else if (fire) begin
      ph_q  <= ph_d;
      idx_q <= (cur_idx == IDX_MAX) ? IDX_MAX : cur_idx + 1'b1;
      if (sof)                                proto_q  <= '0;
      if (cur_idx == IDX_W'(PROTO_IDX))       proto_q  <= data[23:16];
      if (cur_idx == IDX_W'(SRC_IDX))         src_addr <= data;
      if (cur_idx == IDX_W'(DST_IDX))         dst_addr <= data;
    end
  end
endmodule

// File: rtl/udpck_sum.sv
module udpck_sum
  import udpck_pkg::*;
#(
  parameter logic [7:0] PROTO_UDP = 8'd17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [WORD_W-1:0] data,
  input  logic              sod,
  input  logic              hdr2,
  input  logic              pay,
  input  logic [WORD_W-1:0] src_addr,
  input  logic [WORD_W-1:0] dst_addr,
  output logic              ck_ok
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [15:0]      rem_q, rem_d, len_w;
  logic             zero_q, zero_d;
  logic [7:0]       b3, b2, b1, b0;

  assign len_w = data[31:16];

  // bytes beyond the datagram length are forced to zero
  assign b3 = (rem_q >= 16'd1) ? data[31:24] : 8'h00;
  assign b2 = (rem_q >= 16'd2) ? data[23:16] : 8'h00;
  assign b1 = (rem_q >= 16'd3) ? data[15:8]  : 8'h00;
  assign b0 = (rem_q >= 16'd4) ? data[7:0]   : 8'h00;

  always_comb begin
    acc_d  = acc_q;
    rem_d  = rem_q;
    zero_d = zero_q;
    if (sod) begin
      acc_d  = ACC_W'(src_addr[31:16]) + ACC_W'(src_addr[15:0])
             + ACC_W'(dst_addr[31:16]) + ACC_W'(dst_addr[15:0])
             + ACC_W'(PROTO_UDP)
             + ACC_W'(data[31:16]) + ACC_W'(data[15:0]);
      rem_d  = '0;
      zero_d = 1'b0;
    end else if (hdr2) begin
      acc_d  = acc_q + ACC_W'(len_w) + ACC_W'(len_w) + ACC_W'(data[15:0]);
      rem_d  = (len_w >= 16'd8) ? len_w - 16'd8 : 16'd0;
      zero_d = (data[15:0] == 16'h0000);
    end else if (pay) begin
      acc_d  = acc_q + ACC_W'({b3, b2}) + ACC_W'({b1, b0});
      rem_d  = (rem_q >= 16'd4) ? rem_q - 16'd4 : 16'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      rem_q  <= '0;
      zero_q <= 1'b0;
    end else if (fire) begin
      acc_q  <= acc_d;
      rem_q  <= rem_d;
      zero_q <= zero_d;
    end
  end

  assign ck_ok = zero_q || (fold16(acc_q) == 16'hFFFF);
endmodule

// File: rtl/udpck_stage.sv
module udpck_stage
  import udpck_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] d_data,
  input  logic              d_sof,
  input  logic              d_sop,
  input  logic              d_eof,
  input  logic              d_sod,
  input  logic              d_ckv,
  input  logic              d_cko,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] q_data,
  output logic              q_sof,
  output logic              q_sop,
  output logic              q_eof,
  output logic              q_sod,
  output logic              q_ckv,
  output logic              q_cko
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q_data    <= '0;
      q_sof     <= 1'b0;
      q_sop     <= 1'b0;
      q_eof     <= 1'b0;
      q_sod     <= 1'b0;
      q_ckv     <= 1'b0;
      q_cko     <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        q_data <= d_data;
        q_sof  <= d_sof;
        q_sop  <= d_sop;
        q_eof  <= d_eof;
        q_sod  <= d_sod;
        q_ckv  <= d_ckv;
        q_cko  <= d_cko;
      end
    end
  end
endmodule

// File: rtl/udp_dgram_check.sv
module udp_dgram_check
  import udpck_pkg::*;
#(
  parameter logic [7:0] PROTO_UDP = 8'd17,
  parameter int         IDX_W     = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  input  logic        in_sof,
  input  logic        in_sop,
  input  logic        in_eof,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic        out_sof,
  output logic        out_sop,
  output logic        out_eof,
  output logic        out_sod,
  output logic        out_ck_vld,
  output logic        out_ck_ok
);
  logic              fire, sod, hdr2, pay, tail, ck_ok;
  logic [WORD_W-1:0] src_addr, dst_addr;

  assign fire = in_valid && in_ready;

  udpck_hdr_track #(.IDX_W(IDX_W), .PROTO_UDP(PROTO_UDP)) u_trk (
    .clk(clk), .rst_n(rst_n), .fire(fire), .data(in_data),
    .sof(in_sof), .sop(in_sop), .eof(in_eof),
    .sod(sod), .hdr2(hdr2), .pay(pay), .tail(tail),
    .src_addr(src_addr), .dst_addr(dst_addr)
  );

  udpck_sum #(.PROTO_UDP(PROTO_UDP)) u_sum (
    .clk(clk), .rst_n(rst_n), .fire(fire), .data(in_data),
    .sod(sod), .hdr2(hdr2), .pay(pay),
    .src_addr(src_addr), .dst_addr(dst_addr), .ck_ok(ck_ok)
  );

  udpck_stage u_stg (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .d_data(in_data), .d_sof(in_sof), .d_sop(in_sop), .d_eof(in_eof),
    .d_sod(sod), .d_ckv(tail), .d_cko(tail && ck_ok),
    .out_valid(out_valid), .out_ready(out_ready),
    .q_data(out_data), .q_sof(out_sof), .q_sop(out_sop), .q_eof(out_eof),
    .q_sod(out_sod), .q_ckv(out_ck_vld), .q_cko(out_ck_ok)
  );
endmodule

// File: rtl/udpck_chk.sv
module udpck_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        out_sof,
  input logic        out_sop,
  input logic        out_eof,
  input logic        out_sod,
  input logic        out_ck_vld,
  input logic        out_ck_ok
);
  logic ofire, seen_sod_q, last_eof_q;
  assign ofire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_sod_q <= 1'b0;
      last_eof_q <= 1'b0;
    end else if (ofire) begin
      last_eof_q <= out_eof;
      if (out_sof)      seen_sod_q <= 1'b0;
      else if (out_sod) seen_sod_q <= 1'b1;
    end
  end

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sod)
      && $stable(out_eof) && $stable(out_ck_vld) && $stable(out_ck_ok));
  // R4
  sod_on_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sod |-> out_sop);
  // R4
  sod_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ofire && out_sod |-> !seen_sod_q);
  // R8
  ckv_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ck_vld |-> last_eof_q);
  // R8
  ckv_udp_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ck_vld |-> seen_sod_q);
  // R8
  ok_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_ck_ok |-> out_ck_vld);
endmodule

bind udp_dgram_check udpck_chk u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_sof(out_sof), .out_sop(out_sop), .out_eof(out_eof),
  .out_sod(out_sod), .out_ck_vld(out_ck_vld), .out_ck_ok(out_ck_ok)
);

// File: tb/sim_udp_dgram_check.sv
`timescale 1ns/1ps
module sim_udp_dgram_check;
  localparam int NMAX = 4096;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_sof = 1'b0, in_sop = 1'b0, in_eof = 1'b0;
  logic [31:0] in_data = '0;
  logic out_valid, out_ready = 1'b0, out_sof, out_sop, out_eof, out_sod, out_ck_vld, out_ck_ok;
  logic [31:0] out_data;

  always #2 clk = ~clk;

  udp_dgram_check u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_sop(in_sop), .in_eof(in_eof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_sop(out_sop), .out_eof(out_eof), .out_sod(out_sod),
    .out_ck_vld(out_ck_vld), .out_ck_ok(out_ck_ok)
  );

  logic [31:0] w_d [NMAX];
  logic        w_sof[NMAX], w_sop[NMAX], w_eof[NMAX];
  logic        e_sod[NMAX], e_vld[NMAX], e_ok[NMAX];
  int          e_tag[NMAX];
  int nin = 0, ip = 0, nout = 0, nchk = 0, nfail = 0, cyc = 0;
  bit run = 0, clr = 0, hold_prev = 0;
  logic [31:0] hold_data;

  function automatic logic [15:0] fold(input logic [63:0] s);
    while ((s >> 16) != 0) s = (s & 64'hFFFF) + (s >> 16);
    return s[15:0];
  endfunction

  task automatic push(logic [31:0] d, logic s, logic p, logic e, logic sd, logic v, logic ok, int tag);
    w_d[nin] = d; w_sof[nin] = s; w_sop[nin] = p; w_eof[nin] = e;
    e_sod[nin] = sd; e_vld[nin] = v; e_ok[nin] = ok; e_tag[nin] = tag;
    nin++;
  endtask

  // ckm: 0 correct checksum, 1 corrupted, 2 zero field
  task automatic add_frame(int ihl, logic [7:0] proto, int plen, int padw, int ckm, int tag);
    logic [7:0]  pb[64];
    logic [31:0] src, dst, u[32];
    logic [15:0] sp, dp, ulen, ck;
    logic [63:0] s;
    logic udp, ok;
    int nu;
    src = $urandom; dst = $urandom; sp = 16'($urandom); dp = 16'($urandom);
    for (int i = 0; i < 64; i++) pb[i] = 8'($urandom);
    ulen = 16'(8 + plen);
    s = 64'(src[31:16]) + 64'(src[15:0]) + 64'(dst[31:16]) + 64'(dst[15:0])
      + 64'd17 + 64'(ulen) + 64'(sp) + 64'(dp) + 64'(ulen);
    for (int i = 0; i < plen; i += 2)
      s += 64'({pb[i], (i + 1 < plen) ? pb[i+1] : 8'h00});
    ck = ~fold(s);
    if (ck == 16'h0000) ck = 16'hFFFF;
    if (ckm == 1) ck = (ck == 16'hFFFF) ? 16'hFFFE : ck + 16'd1;
    if (ckm == 2) ck = 16'h0000;
    ok  = (ckm != 1);
    udp = (proto == 8'd17);
    u[0] = {sp, dp}; u[1] = {ulen, ck}; nu = 2;
    for (int i = 0; i < (plen + 3) / 4; i++) begin
      u[nu] = {pb[4*i], pb[4*i+1], pb[4*i+2], pb[4*i+3]}; nu++;
    end
    for (int i = 0; i < padw; i++) begin u[nu] = $urandom; nu++; end
    push({4'h4, 4'(ihl), 8'h00, 16'(ihl * 4 + nu * 4)}, 1, 0, 0, 0, 0, 0, tag);
    push($urandom, 0, 0, 0, 0, 0, 0, tag);
    push({8'h40, proto, 16'h5A5A}, 0, 0, 0, 0, 0, 0, tag);
    push(src, 0, 0, 0, 0, 0, 0, tag);
    push(dst, 0, 0, 0, 0, 0, 0, tag);
    for (int i = 5; i < ihl; i++) push($urandom, 0, 0, 0, 0, 0, 0, tag);
    for (int i = 0; i < nu; i++)
      push(u[i], 0, i == 0, i == nu - 1, udp && i == 0, 0, 0, tag);
    push($urandom, 0, 0, 0, 0, udp, udp && ok, tag);
    push($urandom, 0, 0, 0, 0, 0, 0, tag);
  endtask

  function automatic string tname(int t);
    case (t)
      3: return "R3";
      6: return "R6";
      7: return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(bit cond, string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!cond) begin
      nfail++;
      $display("FAIL %s beat %0d actual=%h expected=%h", req, nout, act, exp);
    end
  endtask

  always @(negedge clk) if (run) begin
    cyc++;
    if (hold_prev) chk(out_valid && out_data == hold_data, "R2 hold", out_data, hold_data);
    if (clr) begin in_valid = 1'b0; clr = 0; end
    if (!in_valid && ip < nin && ($urandom % 5) != 0) begin
      in_valid = 1'b1; in_data = w_d[ip]; in_sof = w_sof[ip]; in_sop = w_sop[ip]; in_eof = w_eof[ip];
    end
    out_ready = ($urandom % 4) != 0;
    #1;
    chk(in_ready == (!out_valid || out_ready), "R2 ready", 32'(in_ready), 32'(!out_valid || out_ready));
    if (in_valid && in_ready) begin ip++; clr = 1; end
    if (out_valid && out_ready) begin
      chk(nout < nin && out_data == w_d[nout] && out_sof == w_sof[nout] && out_sop == w_sop[nout]
          && out_eof == w_eof[nout], "R1 beat", out_data, w_d[nout]);
      chk(out_sod == e_sod[nout], (e_tag[nout] == 3) ? "R3/R4 sod" : "R4 sod",
          32'(out_sod), 32'(e_sod[nout]));
      chk(out_ck_vld == e_vld[nout], "R8 ck_vld", 32'(out_ck_vld), 32'(e_vld[nout]));
      chk(out_ck_ok == e_ok[nout], tname(e_tag[nout]), 32'(out_ck_ok), 32'(e_ok[nout]));
      nout++;
    end
    hold_prev = out_valid && !out_ready;
    hold_data = out_data;
  end

  initial begin
    void'($urandom(32'd7331));
    // directed corner cases
    add_frame(5, 8'd17, 16, 0, 0, 5);   // R5 correct sum
    add_frame(5, 8'd17, 16, 0, 1, 5);   // R5 corrupted
    add_frame(6, 8'd6, 12, 0, 0, 3);    // R3 non-UDP, options present
    add_frame(6, 8'd17, 9, 0, 0, 3);    // R3 UDP behind options
    add_frame(5, 8'd17, 20, 0, 2, 6);   // R6 zero field
    add_frame(5, 8'd17, 13, 2, 0, 7);   // R7 odd length plus padding
    add_frame(5, 8'd17, 13, 1, 1, 7);   // R7 corrupted odd
    add_frame(5, 8'd17, 0, 0, 0, 5);    // eof on second header word
    for (int f = 0; f < 40; f++) begin
      int k;
      k = int'($urandom % 8);
      add_frame(5 + int'($urandom % 2), (k == 0) ? 8'd6 : 8'd17, int'($urandom % 41),
                int'($urandom % 3), (k < 3) ? 0 : int'($urandom % 3),
                (k == 0) ? 3 : 7);
    end
    repeat (3) @(negedge clk);
    // R9 reset state
    nchk++;
    if (out_valid || out_sod || out_ck_vld) begin
      nfail++;
      $display("FAIL R9 actual=%b%b%b expected=000", out_valid, out_sod, out_ck_vld);
    end
    rst_n = 1'b1;
    @(negedge clk);
    nchk++;
    if (out_valid) begin nfail++; $display("FAIL R9 actual=1 expected=0 after reset"); end
    run = 1;
    while (nout < nin && cyc < 150000) @(negedge clk);
    if (nout != nin) begin
      nchk++; nfail++;
      $display("FAIL R1 watchdog beats out actual=%0d expected=%0d", nout, nin);
    end
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule